// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Unit

This block settles conditional branches and jumps while the instruction is still in the decode stage of a five-stage in-order pipeline. It picks each of the two compare operands from the register-file read data, or from the ALU result waiting in the EX/MEM register. It tests them for equality with a bit-wise difference reduction instead of a subtraction. It then forms the next fetch address: the sequential PC+4, the branch target, or the jump target.

The unit also checks whether a compare operand is still being produced further down the pipe. An ALU result one instruction ahead is not yet written. A load result one or two instructions ahead is not yet loaded. In those cases the unit raises a stall. The surrounding pipeline uses the stall to hold the PC and IF/ID and to write zeroed control values into ID/EX. A taken branch or a jump raises a flush, which clears the instruction field of IF/ID to zero (a no-op) and costs one bubble. The unit is purely combinational; the register file writes in the first half of a cycle and reads in the second, so nothing is forwarded from MEM/WB.

Top module: `dbr_unit`

## Requirements
- R1: A conditional branch with `br_ne_i`=0 is taken when its two resolved operands are equal; with `br_ne_i`=1 it is taken when they differ. `taken_o` reports this, and it is 0 while stalled or when `branch_i`=0.
- R2: `fwd_rs_o` is 1 exactly when `branch_i`=1, `mem_wen_i`=1, `mem_rd_i` is nonzero and `mem_rd_i` equals `rs_i`; the rs operand is then `mem_alu_i`, otherwise `rs_rdata_i`.
- R3: `fwd_rt_o` follows the same rule for `rt_i`, selecting `mem_alu_i` in place of `rt_rdata_i`.
- R4: `stall_o` is 1 when a branch operand register equals `ex_rd_i` with `ex_wen_i`=1 and `ex_load_i`=0 (one stall cycle).
- R5: `stall_o` is 1 when a branch operand register equals `ex_rd_i` with `ex_wen_i`=1 and `ex_load_i`=1; as the load moves on to EX/MEM, this gives two stall cycles in total.
- R6: `stall_o` is 1 when a branch operand register equals `mem_rd_i` with `mem_wen_i`=1 and `mem_load_i`=1 (one stall cycle).
- R7: Register number 0 never causes forwarding or a stall.
- R8: A taken branch gives `flush_o`=1 and `next_pc_o` = `pc4_i` + (`imm_i` shifted left by 2).
- R9: `jump_i`=1 gives `flush_o`=1 and `next_pc_o` = {`pc4_i`[XLEN-1:XLEN-4], `jidx_i`, 2'b00}.
- R10: While `stall_o`=1, `flush_o` and `taken_o` are 0 and `next_pc_o` equals `pc4_i`: the stall outranks the flush.
- R11: With no taken branch and no jump, `flush_o`=0 and `next_pc_o`=`pc4_i`.
- R12: When `branch_i`=0 (including jumps), `stall_o`, `fwd_rs_o` and `fwd_rt_o` are 0 whatever the producer fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| branch_i | input | 1 | Decode holds a conditional branch |
| br_ne_i | input | 1 | Branch is taken on inequality instead of equality |
| jump_i | input | 1 | Decode holds an unconditional jump |
| rs_i | input | RAW | First compare register number |
| rt_i | input | RAW | Second compare register number |
| rs_rdata_i | input | XLEN | Register-file data for rs |
| rt_rdata_i | input | XLEN | Register-file data for rt |
| imm_i | input | XLEN | Sign-extended branch offset, in words |
| jidx_i | input | XLEN-6 | Jump word index field |
| pc4_i | input | XLEN | Address of the decoded instruction plus 4 |
| ex_rd_i | input | RAW | Destination in ID/EX |
| ex_wen_i | input | 1 | ID/EX instruction writes a register |
| ex_load_i | input | 1 | ID/EX instruction is a load |
| mem_rd_i | input | RAW | Destination in EX/MEM |
| mem_wen_i | input | 1 | EX/MEM instruction writes a register |
| mem_load_i | input | 1 | EX/MEM instruction is a load |
| mem_alu_i | input | XLEN | ALU result held in EX/MEM |
| fwd_rs_o | output | 1 | rs operand taken from EX/MEM |
| fwd_rt_o | output | 1 | rt operand taken from EX/MEM |
| stall_o | output | 1 | Hold PC and IF/ID, zero ID/EX control |
| taken_o | output | 1 | Conditional branch taken |
| flush_o | output | 1 | Clear the IF/ID instruction field |
| next_pc_o | output | XLEN | Next fetch address |

## Verification
The bench builds the unit with XLEN=32 and RAW=3. With only eight register numbers, randomly drawn operands collide with the ID/EX and EX/MEM destinations in a large share of cycles, and register 0 comes up often. Back-to-back load-then-branch pairs, two-stage stalls and forwarded compares are therefore all frequent. A full 32-bit word keeps the jump field at its natural 26 bits, so the region splice of the jump target is exercised at its real position. The bench's pipeline model counts the stall cycles each branch actually receives and compares that count with the distance to its producer.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int unsigned NUM_OPND = 2;
  localparam int unsigned OPND_RS  = 0;
  localparam int unsigned OPND_RT  = 1;

  typedef enum logic [1:0] {
    HZ_NONE,
    HZ_EX_ALU,
    HZ_EX_LOAD,
    HZ_MEM_LOAD
  } hz_kind_e;
endpackage

// File: rtl/dbr_opnd.sv
module dbr_opnd
  import dbr_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RAW  = 5
) (
  input  logic            is_br_i,
  input  logic [RAW-1:0]  src_i,
  input  logic [XLEN-1:0] rf_data_i,
  input  logic [RAW-1:0]  ex_rd_i,
  input  logic            ex_wen_i,
  input  logic            ex_load_i,
  input  logic [RAW-1:0]  mem_rd_i,
  input  logic            mem_wen_i,
  input  logic            mem_load_i,
  input  logic [XLEN-1:0] mem_data_i,
  output logic            fwd_o,
  output hz_kind_e        hz_o,
  output logic [XLEN-1:0] opnd_o
);
  logic src_live, ex_hit, mem_hit;

  // $0 is hard-wired, never a dependency
  assign src_live = is_br_i && (src_i != '0);
  assign ex_hit   = src_live && ex_wen_i  && (ex_rd_i  == src_i);
  assign mem_hit  = src_live && mem_wen_i && (mem_rd_i == src_i);

  assign fwd_o  = mem_hit;
  assign opnd_o = mem_hit ? mem_data_i : rf_data_i;

  always_comb begin
    if (ex_hit && ex_load_i)        hz_o = HZ_EX_LOAD;
    else if (ex_hit)                hz_o = HZ_EX_ALU;
    else if (mem_hit && mem_load_i) hz_o = HZ_MEM_LOAD;
    else                            hz_o = HZ_NONE;
  end
endmodule

// File: rtl/dbr_eq_cmp.sv
module dbr_eq_cmp #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            eq_o
);
  logic [XLEN-1:0] diff;

  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    assign diff[i] = a_i[i] ^ b_i[i];
  end

  assign eq_o = ~(|diff);
endmodule

// File: rtl/dbr_target.sv
module dbr_target #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned JW   = 26
) (
  input  logic [XLEN-1:0] pc4_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic [JW-1:0]   jidx_i,
  output logic [XLEN-1:0] br_tgt_o,
  output logic [XLEN-1:0] jmp_tgt_o
);
  localparam int unsigned RGN_W = XLEN - JW - 2;

  logic [XLEN-1:0] off_bytes;

  assign off_bytes = {imm_i[XLEN-3:0], 2'b00};
  assign br_tgt_o  = pc4_i + off_bytes;
  assign jmp_tgt_o = {pc4_i[XLEN-1 -: RGN_W], jidx_i, 2'b00};
endmodule

// File: rtl/dbr_unit.sv
module dbr_unit
  import dbr_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RAW  = 5,
  localparam int unsigned JW  = XLEN - 6
) (
  input  logic            branch_i,
  input  logic            br_ne_i,
  input  logic            jump_i,
  input  logic [RAW-1:0]  rs_i,
  input  logic [RAW-1:0]  rt_i,
  input  logic [XLEN-1:0] rs_rdata_i,
  input  logic [XLEN-1:0] rt_rdata_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic [JW-1:0]   jidx_i,
  input  logic [XLEN-1:0] pc4_i,
  input  logic [RAW-1:0]  ex_rd_i,
  input  logic            ex_wen_i,
  input  logic            ex_load_i,
  input  logic [RAW-1:0]  mem_rd_i,
  input  logic            mem_wen_i,
  input  logic            mem_load_i,
  input  logic [XLEN-1:0] mem_alu_i,
  output logic            fwd_rs_o,
  output logic            fwd_rt_o,
  output logic            stall_o,
  output logic            taken_o,
  output logic            flush_o,
  output logic [XLEN-1:0] next_pc_o
);
  logic [RAW-1:0]  src     [NUM_OPND];
  logic [XLEN-1:0] rf_data [NUM_OPND];
  logic [XLEN-1:0] opnd    [NUM_OPND];
  logic [NUM_OPND-1:0] fwd, hz_any;
  hz_kind_e        hz      [NUM_OPND];

  logic            ops_eq, cond_met;
  logic [XLEN-1:0] br_tgt, jmp_tgt;

  assign src[OPND_RS]     = rs_i;
  assign src[OPND_RT]     = rt_i;
  assign rf_data[OPND_RS] = rs_rdata_i;
  assign rf_data[OPND_RT] = rt_rdata_i;

  for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
    dbr_opnd #(.XLEN(XLEN), .RAW(RAW)) opnd_i (
      .is_br_i    (branch_i),
      .src_i      (src[k]),
      .rf_data_i  (rf_data[k]),
      .ex_rd_i    (ex_rd_i),
      .ex_wen_i   (ex_wen_i),
      .ex_load_i  (ex_load_i),
      .mem_rd_i   (mem_rd_i),
      .mem_wen_i  (mem_wen_i),
      .mem_load_i (mem_load_i),
      .mem_data_i (mem_alu_i),
      .fwd_o      (fwd[k]),
      .hz_o       (hz[k]),
      .opnd_o     (opnd[k])
    );
    assign hz_any[k] = (hz[k] != HZ_NONE);
  end

  dbr_eq_cmp #(.XLEN(XLEN)) cmp_i (
    .a_i  (opnd[OPND_RS]),
    .b_i  (opnd[OPND_RT]),
    .eq_o (ops_eq)
  );

  dbr_target #(.XLEN(XLEN), .JW(JW)) tgt_i (
    .pc4_i     (pc4_i),
    .imm_i     (imm_i),
    .jidx_i    (jidx_i),
    .br_tgt_o  (br_tgt),
    .jmp_tgt_o (jmp_tgt)
  );

  assign fwd_rs_o = fwd[OPND_RS];
  assign fwd_rt_o = fwd[OPND_RT];
  assign stall_o  = |hz_any;
  assign cond_met = br_ne_i ? ~ops_eq : ops_eq;
  assign taken_o  = branch_i && cond_met && !stall_o;
  // stall outranks flush: the branch is re-evaluated once operands are ready
  assign flush_o  = (taken_o || jump_i) && !stall_o;

  always_comb begin
    if (!flush_o)    next_pc_o = pc4_i;
    else if (jump_i) next_pc_o = jmp_tgt;
    else             next_pc_o = br_tgt;
  end
endmodule

// File: rtl/dbr_unit_chk.sv
module dbr_unit_chk #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned RAW  = 5,
  localparam int unsigned JW  = XLEN - 6
) (
  input logic            branch_i,
  input logic            br_ne_i,
  input logic            jump_i,
  input logic [RAW-1:0]  rs_i,
  input logic [RAW-1:0]  rt_i,
  input logic [XLEN-1:0] rs_rdata_i,
  input logic [XLEN-1:0] rt_rdata_i,
  input logic [XLEN-1:0] imm_i,
  input logic [JW-1:0]   jidx_i,
  input logic [XLEN-1:0] pc4_i,
  input logic [RAW-1:0]  ex_rd_i,
  input logic            ex_wen_i,
  input logic            ex_load_i,
  input logic [RAW-1:0]  mem_rd_i,
  input logic            mem_wen_i,
  input logic            mem_load_i,
  input logic [XLEN-1:0] mem_alu_i,
  input logic            fwd_rs_o,
  input logic            fwd_rt_o,
  input logic            stall_o,
  input logic            taken_o,
  input logic            flush_o,
  input logic [XLEN-1:0] next_pc_o
);
  // Combinational block: immediate assertions evaluated on settled inputs
  always_comb begin
    a_r10_stall_blocks_flush: assert (!(stall_o && (flush_o || taken_o)))
      else $error("stall with flush/taken");
    a_r10_stall_keeps_seq_pc: assert (!stall_o || (next_pc_o == pc4_i))
      else $error("stall redirected pc");
    a_r7_zero_rs_no_fwd: assert (!(rs_i == '0 && fwd_rs_o))
      else $error("forward on $0 rs");
    a_r7_zero_rt_no_fwd: assert (!(rt_i == '0 && fwd_rt_o))
      else $error("forward on $0 rt");
    a_r12_nonbranch_quiet: assert (branch_i || !(stall_o || fwd_rs_o || fwd_rt_o))
      else $error("hazard raised for non-branch");
    a_r9_jump_flushes: assert (!jump_i || branch_i || flush_o)
      else $error("jump without flush");
    a_r8_taken_flushes: assert (!taken_o || flush_o)
      else $error("taken without flush");
    a_r2_fwd_rs_source: assert (!fwd_rs_o || (mem_wen_i && mem_rd_i == rs_i))
      else $error("rs forward without producer");
    a_r3_fwd_rt_source: assert (!fwd_rt_o || (mem_wen_i && mem_rd_i == rt_i))
      else $error("rt forward without producer");
    a_r11_no_redirect_seq: assert (flush_o || (next_pc_o == pc4_i))
      else $error("redirect without flush");
  end
endmodule

bind dbr_unit dbr_unit_chk #(.XLEN(XLEN), .RAW(RAW)) chk_i (.*);

// File: tb/dbr_unit_tb_top.sv
module dbr_unit_tb_top;
  localparam int unsigned XLEN = 32;
  localparam int unsigned RAW  = 3;
  localparam int unsigned JW   = XLEN - 6;
  localparam int NCYC = 4000;

  localparam int K_NOP = 0, K_ALU = 1, K_LD = 2, K_BEQ = 3, K_BNE = 4, K_JMP = 5;

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic            branch, br_ne, jump;
  logic [RAW-1:0]  rs, rt, ex_rd, mem_rd;
  logic [XLEN-1:0] rs_rdata, rt_rdata, imm, pc4, mem_alu, next_pc;
  logic [JW-1:0]   jidx;
  logic            ex_wen, ex_load, mem_wen, mem_load;
  logic            fwd_rs, fwd_rt, stall, taken, flush;

  dbr_unit #(.XLEN(XLEN), .RAW(RAW)) dut_i (
    .branch_i(branch), .br_ne_i(br_ne), .jump_i(jump),
    .rs_i(rs), .rt_i(rt), .rs_rdata_i(rs_rdata), .rt_rdata_i(rt_rdata),
    .imm_i(imm), .jidx_i(jidx), .pc4_i(pc4),
    .ex_rd_i(ex_rd), .ex_wen_i(ex_wen), .ex_load_i(ex_load),
    .mem_rd_i(mem_rd), .mem_wen_i(mem_wen), .mem_load_i(mem_load),
    .mem_alu_i(mem_alu),
    .fwd_rs_o(fwd_rs), .fwd_rt_o(fwd_rt), .stall_o(stall),
    .taken_o(taken), .flush_o(flush), .next_pc_o(next_pc)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // reference pipeline state
  int              d_kind;
  logic [RAW-1:0]  d_rs, d_rt, d_rd;
  logic [XLEN-1:0] d_rsv, d_rtv, d_imm, d_pc4;
  logic [JW-1:0]   d_jidx;
  logic [RAW-1:0]  m_ex_rd, m_mem_rd;
  bit              m_ex_wen, m_ex_ld, m_mem_wen, m_mem_ld;
  logic [XLEN-1:0] m_ex_val, m_mem_val;
  bit              exp_stall;
  int              want_stalls, seen_stalls;

  function automatic int pick_kind();
    int r = int'($urandom % 100);
    if (r < 35) return K_ALU;
    if (r < 55) return K_LD;
    if (r < 72) return K_BEQ;
    if (r < 85) return K_BNE;
    if (r < 95) return K_JMP;
    return K_NOP;
  endfunction

  function automatic bit is_br(int k);
    return (k == K_BEQ) || (k == K_BNE);
  endfunction

  // stall budget from producer distance at the moment a branch enters decode
  function automatic int stall_budget();
    int worst = 0;
    logic [RAW-1:0] s;
    for (int k = 0; k < 2; k++) begin
      s = (k == 0) ? d_rs : d_rt;
      if (s != 0) begin
        if (m_ex_wen && m_ex_rd == s) worst = m_ex_ld ? 2 : (worst > 1 ? worst : 1);
        if (m_mem_wen && m_mem_ld && m_mem_rd == s && worst < 1) worst = 1;
      end
    end
    return worst;
  endfunction

  task automatic new_decode();
    d_kind = pick_kind();
    d_rs   = RAW'($urandom);
    d_rt   = RAW'($urandom);
    d_rd   = RAW'($urandom);
    d_rsv  = XLEN'($urandom % 4);
    d_rtv  = XLEN'($urandom % 4);
    d_imm  = XLEN'($signed(16'($urandom)));
    d_jidx = JW'($urandom);
    d_pc4  = {XLEN'($urandom)} & ~XLEN'(3);
    seen_stalls = 0;
    if (is_br(d_kind)) want_stalls = stall_budget();
  endtask

  task automatic drive();
    branch   = is_br(d_kind);
    br_ne    = (d_kind == K_BNE);
    jump     = (d_kind == K_JMP);
    rs = d_rs; rt = d_rt; rs_rdata = d_rsv; rt_rdata = d_rtv;
    imm = d_imm; jidx = d_jidx; pc4 = d_pc4;
    ex_rd = m_ex_rd; ex_wen = m_ex_wen; ex_load = m_ex_ld;
    mem_rd = m_mem_rd; mem_wen = m_mem_wen; mem_load = m_mem_ld; mem_alu = m_mem_val;
  endtask

  task automatic check_cycle();
    bit br, e_stall, e_taken, e_flush, f_rs, f_rt, ex_h, ld_h, mem_h;
    logic [XLEN-1:0] a, b, e_pc;
    string stag, ftag;
    logic [RAW-1:0] s;
    br = is_br(d_kind);
    ex_h = 0; ld_h = 0; mem_h = 0;
    for (int k = 0; k < 2; k++) begin
      s = (k == 0) ? d_rs : d_rt;
      if (br && s != 0) begin
        if (m_ex_wen && m_ex_rd == s) begin
          if (m_ex_ld) ld_h = 1; else ex_h = 1;
        end
        if (m_mem_wen && m_mem_ld && m_mem_rd == s) mem_h = 1;
      end
    end
    e_stall = ex_h || ld_h || mem_h;
    f_rs = br && d_rs != 0 && m_mem_wen && m_mem_rd == d_rs;
    f_rt = br && d_rt != 0 && m_mem_wen && m_mem_rd == d_rt;
    a = f_rs ? m_mem_val : d_rsv;
    b = f_rt ? m_mem_val : d_rtv;
    e_taken = br && !e_stall && ((d_kind == K_BEQ) == (a == b));
    e_flush = !e_stall && (e_taken || d_kind == K_JMP);
    if (!e_flush)              e_pc = d_pc4;
    else if (d_kind == K_JMP)  e_pc = {d_pc4[XLEN-1:XLEN-4], d_jidx, 2'b00};
    else                       e_pc = d_pc4 + d_imm * 4;

    if (!br)        stag = "R12";
    else if (ld_h)  stag = "R5";
    else if (ex_h)  stag = "R4";
    else if (mem_h) stag = "R6";
    else            stag = "R7";
    if (e_stall)               ftag = "R10";
    else if (d_kind == K_JMP)  ftag = "R9";
    else if (e_taken)          ftag = "R8";
    else                       ftag = "R11";

    chk(stag, "stall", XLEN'(stall), XLEN'(e_stall));
    chk((d_rs == 0) ? "R7" : (br ? "R2" : "R12"), "fwd_rs", XLEN'(fwd_rs), XLEN'(f_rs));
    chk((d_rt == 0) ? "R7" : (br ? "R3" : "R12"), "fwd_rt", XLEN'(fwd_rt), XLEN'(f_rt));
    chk(e_stall ? "R10" : "R1", "taken", XLEN'(taken), XLEN'(e_taken));
    chk(ftag, "flush", XLEN'(flush), XLEN'(e_flush));
    chk(ftag, "next_pc", next_pc, e_pc);
    exp_stall = e_stall;
    if (br && stall) seen_stalls++;
  endtask

  task automatic advance();
    if (is_br(d_kind) && !exp_stall)
      chk((want_stalls == 2) ? "R5" : ((want_stalls == 1) ? "R4" : "R1"),
          "stall_count", XLEN'(seen_stalls), XLEN'(want_stalls));
    m_mem_rd = m_ex_rd; m_mem_wen = m_ex_wen; m_mem_ld = m_ex_ld; m_mem_val = m_ex_val;
    if (exp_stall) begin
      // zeroed control into ID/EX
      m_ex_rd = '0; m_ex_wen = 0; m_ex_ld = 0; m_ex_val = '0;
    end else begin
      m_ex_rd  = d_rd;
      m_ex_wen = (d_kind == K_ALU) || (d_kind == K_LD);
      m_ex_ld  = (d_kind == K_LD);
      m_ex_val = XLEN'($urandom % 4);
      new_decode();
    end
  endtask

  initial begin
    m_ex_rd = '0; m_ex_wen = 0; m_ex_ld = 0; m_ex_val = '0;
    m_mem_rd = '0; m_mem_wen = 0; m_mem_ld = 0; m_mem_val = '0;
    d_kind = K_NOP; d_rs = '0; d_rt = '0; d_rd = '0; d_rsv = '0; d_rtv = '0;
    d_imm = '0; d_jidx = '0; d_pc4 = '0; exp_stall = 0;
    want_stalls = 0; seen_stalls = 0;
    drive();
    repeat (3) @(posedge clk);
    #4;
    chk("R11", "reset stall", XLEN'(stall), '0);
    chk("R11", "reset flush", XLEN'(flush), '0);
    chk("R11", "reset next_pc", next_pc, '0);
    rst_n = 1;
    new_decode();
    for (int c = 0; c < NCYC; c++) begin
      @(posedge clk);
      if (c != 0) advance();
      #1 drive();
      #3 check_cycle();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #((NCYC + 100) * 10 * 2);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule